// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Controller

This block lets the harts of a four-hart cluster interrupt one another through a small memory-mapped register file. It handles software-raised requests only. No external interrupt line feeds it. Each request source is a (sender, receiver) pair, and each pair owns one bit of a shared 32-bit pending word. A sending hart sets the bit that names the receiver inside the sender's own eight-bit slice of that word. The receiver sees a level interrupt. It reads its claim register to learn the source ID, and it writes the same ID back to that register when it has finished handling the request.

Inside a sender's slice the bit-to-receiver order is reversed. The top bit of the slice addresses hart 0, the next bit down addresses hart 1, and so on. The lower half of each slice addresses no hart. Every source has a priority register, and each hart has an enable word. Software normally programs each hart's enable word so that it selects only the bits aimed at that hart. A priority of zero silences a source. The controller arbitrates among pending, enabled, nonzero-priority sources for each hart, and it keeps a per-hart record of claimed sources until they are completed.

The register bus is single-cycle. A request is `bus_valid` together with `bus_write`, a byte address and a write word. Read data is registered and appears on `bus_rdata` after the clock edge that accepted the read. It holds that value until the next read.

Top module: `ipi_softirq_ctrl`

## Requirements
- R1: The pending word at offset 0x1000 is write-one-to-set. A written 1 sets the matching bit, a written 0 leaves the bit as it was, and a read returns the current pending word.
- R2: A request from sender s to receiver t uses pending bit 8*s + (7 - t), and its source ID is that bit index plus 1. Setting that bit interrupts hart t only, provided hart t has it enabled.
- R3: Source ID n (1 to 32) has a priority register at offset 4*n. It holds 3 bits and reads back what was written. A source whose priority is 0 never raises an interrupt and is never returned by a claim.
- R4: Hart h has an enable word at offset 0x2000 + 0x80*h that reads back what was written. A pending source whose enable bit is 0 for hart h never interrupts hart h.
- R5: `irq[h]` is high exactly while some source is pending, enabled for h, of nonzero priority and not in progress on h.
- R6: A read of hart h's claim register at offset 0x200004 + 0x1000*h returns the ID of the eligible source with the highest priority. On equal priority the lowest ID wins. When no source is eligible the read returns 0.
- R7: A claim that returns a nonzero ID clears that source's pending bit and marks the source in progress on hart h. While it is in progress, a fresh request from that source neither raises `irq[h]` nor is claimed by h.
- R8: A write of ID n to hart h's claim register ends n's in-progress state on h. A written value that is 0, above 32, or not in progress on h changes nothing.
- R9: A read of any other offset, including offset 0 and misaligned addresses, returns 0. A write to such an offset changes no state.
- R10: After reset every priority, enable, pending and in-progress bit is 0, all `irq` lines are low and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (24) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the last read |
| irq | output | N_HARTS (4) | Level interrupt, one per hart |

## Verification
The assertions assume one bus access per cycle. As a result, a claim and a completion for the same hart never happen in the same cycle, and a pending-word write never happens in the same cycle as a claim. The properties that say an ignored completion leaves the in-progress state unchanged, and that a set pending bit survives into the next cycle, depend on this assumption. The bench issues every access through a single task that drives one request per clock and releases `bus_valid` straight after the edge, so this condition always holds. The same task keeps every address at the 24-bit width and word-aligned, except for the one deliberate misaligned case.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int unsigned DATA_W = 32;

  // Address map (byte offsets)
  localparam logic [31:0] PEND_ADDR    = 32'h0000_1000;
  localparam logic [31:0] EN_BASE      = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE    = 32'h0000_0080;
  localparam logic [31:0] CLAIM_BASE   = 32'h0020_0004;
  localparam logic [31:0] CLAIM_STRIDE = 32'h0000_1000;

  // Priority register of source index i (ID i+1) sits at 4*ID.
  function automatic logic [31:0] prio_addr(input int unsigned src_idx);
    return 32'((src_idx + 1) * 4);
  endfunction

  function automatic logic [31:0] en_addr(input int unsigned hart);
    return EN_BASE + 32'(hart) * EN_STRIDE;
  endfunction

  function automatic logic [31:0] claim_addr(input int unsigned hart);
    return CLAIM_BASE + 32'(hart) * CLAIM_STRIDE;
  endfunction

  // A completion value names a real source only when it lies in 1..n_src.
  function automatic logic id_in_range(input logic [31:0] val, input int unsigned n_src);
    return (val != 32'd0) && (val <= 32'(n_src));
  endfunction

endpackage

// File: rtl/ipi_prio_regs.sv
module ipi_prio_regs #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       addr,
  input  logic              wr,
  input  logic [PRIO_W-1:0] wdata,
  output logic [PRIO_W-1:0] prio [N_SRC],
  output logic [N_SRC-1:0]  prio_nz,
  output logic [N_SRC-1:0]  hit
);
  import ipi_pkg::*;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = (addr == prio_addr(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            prio[i] <= '0;
      else if (wr && hit[i]) prio[i] <= wdata;
    end

    assign prio_nz[i] = |prio[i];
  end

  // R3: a priority write is visible in the next cycle
  p_prio_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr && (hit != '0) |=> (prio_nz != '0) == ($past(wdata) != '0) || ($countones($past(hit)) == 1 && prio_nz != '0));

endmodule

// File: rtl/ipi_arbiter.sv
module ipi_arbiter #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 6
) (
  input  logic [N_SRC-1:0]  cand,
  input  logic [PRIO_W-1:0] prio [N_SRC],
  output logic [ID_W-1:0]   win_id
);
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;

  // Linear scan: strictly-greater keeps the lowest ID on a tie.
  always_comb begin
    best_id   = '0;
    best_prio = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && ((best_id == '0) || (prio[i] > best_prio))) begin
        best_id   = ID_W'(i + 1);
        best_prio = prio[i];
      end
    end
  end

  assign win_id = best_id;

endmodule

// File: rtl/ipi_hart_ctx.sv
module ipi_hart_ctx #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned SRC_IW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              claim_rd,
  input  logic              cmpl_we,
  input  logic [31:0]       wdata,
  input  logic [N_SRC-1:0]  pending,
  input  logic [N_SRC-1:0]  prio_nz,
  input  logic [PRIO_W-1:0] prio [N_SRC],
  output logic              irq,
  output logic [N_SRC-1:0]  enable,
  output logic [ID_W-1:0]   claim_id,
  output logic              claim_take,
  output logic [SRC_IW-1:0] claim_idx
);
  import ipi_pkg::*;

  logic [N_SRC-1:0]  active;
  logic [N_SRC-1:0]  cand;
  logic [SRC_IW-1:0] cmpl_idx;
  logic              cmpl_ok;

  assign cand = pending & enable & prio_nz & ~active;
  assign irq  = |cand;

  ipi_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_arb (
    .cand   (cand),
    .prio   (prio),
    .win_id (claim_id)
  );

  assign claim_take = claim_rd && (claim_id != '0);
  assign claim_idx  = SRC_IW'(claim_id - ID_W'(1));

  assign cmpl_idx = SRC_IW'(wdata - 32'd1);
  assign cmpl_ok  = cmpl_we && id_in_range(wdata, N_SRC) && active[cmpl_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable <= '0;
    else if (en_we) enable <= wdata[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else begin
      if (claim_take) active[claim_idx] <= 1'b1;
      if (cmpl_ok)    active[cmpl_idx]  <= 1'b0;
    end
  end

  // R7: a claimed source is in progress in the next cycle
  p_claim_marks_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_take |=> active[$past(claim_idx)]);

  // R8: a completion that does not match an in-progress source changes nothing
  p_bad_complete_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_we && !claim_rd && !cmpl_ok |=> $stable(active));

  // R6: the arbiter only names an eligible source
  p_winner_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_id != '0 |-> cand[claim_idx]);

  // R5: an interrupt always has a claimable source behind it
  p_irq_has_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> claim_id != '0);

  // R3: a zero-priority source is never claimed
  p_zero_prio_not_claimed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    claim_take |-> prio_nz[claim_idx]);

endmodule

// File: rtl/ipi_softirq_ctrl.sv
module ipi_softirq_ctrl #(
  parameter int unsigned N_HARTS  = 4,
  parameter int unsigned REGION_W = 8,
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned ADDR_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_HARTS-1:0] irq
);
  import ipi_pkg::*;

  localparam int unsigned N_SRC  = N_HARTS * REGION_W;
  localparam int unsigned ID_W   = $clog2(N_SRC + 1);
  localparam int unsigned SRC_IW = $clog2(N_SRC);

  logic [31:0]        addr32;
  logic               rd_req, wr_req;
  logic               pend_hit;
  logic [N_HARTS-1:0] en_hit, claim_hit;
  logic [N_SRC-1:0]   prio_hit;
  logic               mapped;

  logic [N_SRC-1:0]   pending, pend_set, pend_clr;
  logic [PRIO_W-1:0]  prio [N_SRC];
  logic [N_SRC-1:0]   prio_nz;

  logic [N_SRC-1:0]   enable    [N_HARTS];
  logic [ID_W-1:0]    claim_id  [N_HARTS];
  logic [SRC_IW-1:0]  claim_idx [N_HARTS];
  logic [N_HARTS-1:0] claim_take;

  logic [31:0]        rd_val;

  assign addr32 = 32'(bus_addr);
  assign rd_req = bus_valid && !bus_write;
  assign wr_req = bus_valid &&  bus_write;

  assign pend_hit = (addr32 == PEND_ADDR);
  assign mapped   = pend_hit || (en_hit != '0) || (claim_hit != '0) || (prio_hit != '0);

  ipi_prio_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr32),
    .wr      (wr_req),
    .wdata   (bus_wdata[PRIO_W-1:0]),
    .prio    (prio),
    .prio_nz (prio_nz),
    .hit     (prio_hit)
  );

  for (genvar h = 0; h < N_HARTS; h++) begin : g_hart
    assign en_hit[h]    = (addr32 == en_addr(h));
    assign claim_hit[h] = (addr32 == claim_addr(h));

    ipi_hart_ctx #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W), .SRC_IW(SRC_IW)) i_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_we      (wr_req && en_hit[h]),
      .claim_rd   (rd_req && claim_hit[h]),
      .cmpl_we    (wr_req && claim_hit[h]),
      .wdata      (bus_wdata),
      .pending    (pending),
      .prio_nz    (prio_nz),
      .prio       (prio),
      .irq        (irq[h]),
      .enable     (enable[h]),
      .claim_id   (claim_id[h]),
      .claim_take (claim_take[h]),
      .claim_idx  (claim_idx[h])
    );
  end

  // Pending word: write-one-to-set, cleared bit by bit on claim.
  assign pend_set = (wr_req && pend_hit) ? bus_wdata[N_SRC-1:0] : '0;

  always_comb begin
    pend_clr = '0;
    for (int h = 0; h < N_HARTS; h++)
      if (claim_take[h]) pend_clr[claim_idx[h]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending | pend_set) & ~pend_clr;
  end

  // Read mux: one-hot address hits OR-ed together.
  always_comb begin
    rd_val = '0;
    if (pend_hit) rd_val = 32'(pending);
    for (int i = 0; i < N_SRC; i++)
      if (prio_hit[i]) rd_val = rd_val | 32'(prio[i]);
    for (int h = 0; h < N_HARTS; h++) begin
      if (en_hit[h])    rd_val = rd_val | 32'(enable[h]);
      if (claim_hit[h]) rd_val = rd_val | 32'(claim_id[h]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_val;
  end

  // R1: bits written as one are set in the next cycle
  p_w1s_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && pend_hit |=> (pending & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]));

  // R9: a write to an unmapped offset leaves the pending word alone
  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !mapped |=> $stable(pending));

  // R9: a read of an unmapped offset returns zero
  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !mapped |=> bus_rdata == 32'd0);

  // R7: at most one hart claims per cycle
  p_single_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_take));

endmodule

// File: tb/test_ipi_softirq_ctrl.sv
`timescale 1ns/1ps
module test_ipi_softirq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ipi_softirq_ctrl i_ipi_softirq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [23:0] addr;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic [3:0]  exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 24'h001000, 32'h0, 32'h0, 4'h0, 4'd10},          // R10 pending clear
    '{1'b0, 24'h002080, 32'h0, 32'h0, 4'h0, 4'd10},          // R10 enable clear
    '{1'b1, 24'h00001C, 32'h1, 32'h0, 4'h0, 4'd3},           // prio id7 = 1
    '{1'b0, 24'h00001C, 32'h0, 32'h1, 4'h0, 4'd3},           // R3 readback
    '{1'b1, 24'h00005C, 32'h2, 32'h0, 4'h0, 4'd3},           // prio id23 = 2
    '{1'b1, 24'h000080, 32'h1, 32'h0, 4'h0, 4'd3},           // prio id32 = 1
    '{1'b1, 24'h00007C, 32'h1, 32'h0, 4'h0, 4'd3},           // prio id31 = 1
    '{1'b1, 24'h002080, 32'h40404040, 32'h0, 4'h0, 4'd4},    // R4 hart1 enable
    '{1'b0, 24'h002080, 32'h0, 32'h40404040, 4'h0, 4'd4},
    '{1'b1, 24'h002000, 32'h80808080, 32'h0, 4'h0, 4'd4},    // hart0 enable
    '{1'b1, 24'h001000, 32'h00000040, 32'h0, 4'h2, 4'd2},    // R2 sender0 -> hart1
    '{1'b1, 24'h001000, 32'h0, 32'h0, 4'h2, 4'd1},           // R1 zero write
    '{1'b0, 24'h001000, 32'h0, 32'h40, 4'h2, 4'd1},
    '{1'b1, 24'h001000, 32'h00400000, 32'h0, 4'h2, 4'd2},    // R2 sender2 -> hart1
    '{1'b0, 24'h201004, 32'h0, 32'd23, 4'h2, 4'd6},          // R6 higher prio wins
    '{1'b0, 24'h001000, 32'h0, 32'h40, 4'h2, 4'd7},          // R7 bit cleared
    '{1'b1, 24'h001000, 32'h00400000, 32'h0, 4'h2, 4'd7},    // re-send id23
    '{1'b0, 24'h201004, 32'h0, 32'd7, 4'h0, 4'd7},           // R7 id23 masked
    '{1'b1, 24'h201004, 32'd5, 32'h0, 4'h0, 4'd8},           // R8 wrong id
    '{1'b1, 24'h201004, 32'd64, 32'h0, 4'h0, 4'd8},          // R8 out of range
    '{1'b1, 24'h201004, 32'd23, 32'h0, 4'h2, 4'd8},          // R8 complete id23
    '{1'b0, 24'h201004, 32'h0, 32'd23, 4'h0, 4'd6},
    '{1'b1, 24'h201004, 32'd23, 32'h0, 4'h0, 4'd8},
    '{1'b1, 24'h201004, 32'd7, 32'h0, 4'h0, 4'd8},
    '{1'b0, 24'h201004, 32'h0, 32'd0, 4'h0, 4'd6},           // R6 none -> 0
    '{1'b1, 24'h000080, 32'h0, 32'h0, 4'h0, 4'd3},           // prio id32 = 0
    '{1'b1, 24'h001000, 32'h80000000, 32'h0, 4'h0, 4'd3},    // R3 silent source
    '{1'b0, 24'h200004, 32'h0, 32'd0, 4'h0, 4'd3},
    '{1'b1, 24'h000080, 32'h1, 32'h0, 4'h1, 4'd5},           // R5 becomes eligible
    '{1'b0, 24'h200004, 32'h0, 32'd32, 4'h0, 4'd6},
    '{1'b1, 24'h200004, 32'd32, 32'h0, 4'h0, 4'd8},
    '{1'b1, 24'h001000, 32'h40000040, 32'h0, 4'h2, 4'd2},    // ids 31 and 7, equal prio
    '{1'b0, 24'h201004, 32'h0, 32'd7, 4'h2, 4'd6},           // R6 tie -> lowest id
    '{1'b1, 24'h201004, 32'd7, 32'h0, 4'h2, 4'd8},
    '{1'b0, 24'h201004, 32'h0, 32'd31, 4'h0, 4'd6},
    '{1'b1, 24'h201004, 32'd31, 32'h0, 4'h0, 4'd8},
    '{1'b1, 24'h000018, 32'h1, 32'h0, 4'h0, 4'd3},           // prio id6 = 1
    '{1'b1, 24'h001000, 32'h00000020, 32'h0, 4'h0, 4'd4},    // R4 hart2 not enabled
    '{1'b1, 24'h002100, 32'h20202020, 32'h0, 4'h4, 4'd4},    // R4 enable -> irq
    '{1'b0, 24'h202004, 32'h0, 32'd6, 4'h0, 4'd6},
    '{1'b1, 24'h202004, 32'd6, 32'h0, 4'h0, 4'd8},
    '{1'b1, 24'h003000, 32'hFFFFFFFF, 32'h0, 4'h0, 4'd9},    // R9 unmapped write
    '{1'b0, 24'h003000, 32'h0, 32'h0, 4'h0, 4'd9},
    '{1'b0, 24'h001000, 32'h0, 32'h0, 4'h0, 4'd9},
    '{1'b0, 24'h000000, 32'h0, 32'h0, 4'h0, 4'd9},
    '{1'b1, 24'h001002, 32'hFFFFFFFF, 32'h0, 4'h0, 4'd9},    // R9 misaligned
    '{1'b0, 24'h001000, 32'h0, 32'h0, 4'h0, 4'd9}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  function automatic int pair_bit(input int sender, input int target);
    return sender * 8 + (7 - target);
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] mask;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk(10, bus_rdata, 32'h0, "rdata after reset");   // R10
    chk(10, 32'(irq), 32'h0, "irq after reset");      // R10

    for (int k = 0; k < NV; k++) begin
      bus_op(TBL[k].wr, TBL[k].addr, TBL[k].data);
      if (!TBL[k].wr) chk(int'(TBL[k].req), bus_rdata, TBL[k].exp_rd, $sformatf("vec %0d read", k));
      chk(int'(TBL[k].req), 32'(irq), 32'(TBL[k].exp_irq), $sformatf("vec %0d irq", k));
    end

    // R10: reset in mid-run with state loaded
    bus_op(1'b1, 24'h001000, 32'h00000040);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(10, 32'(irq), 32'h0, "irq after second reset");
    bus_op(1'b0, 24'h001000, 32'h0);
    chk(10, bus_rdata, 32'h0, "pending after second reset");
    bus_op(1'b0, 24'h00001C, 32'h0);
    chk(10, bus_rdata, 32'h0, "prio after second reset");
    bus_op(1'b0, 24'h002080, 32'h0);
    chk(10, bus_rdata, 32'h0, "enable after second reset");

    // R2: sweep every (sender, receiver) pair
    for (int id = 1; id <= 32; id++) bus_op(1'b1, 24'(id * 4), 32'h1);
    for (int t = 0; t < 4; t++) begin
      mask = '0;
      for (int s = 0; s < 4; s++) mask[pair_bit(s, t)] = 1'b1;
      bus_op(1'b1, 24'(32'h2000 + t * 32'h80), mask);
    end
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        bus_op(1'b1, 24'h001000, 32'h1 << pair_bit(s, t));
        chk(2, 32'(irq), 32'h1 << t, $sformatf("irq for %0d->%0d", s, t));
        bus_op(1'b0, 24'(32'h200004 + t * 32'h1000), 32'h0);
        chk(2, bus_rdata, 32'(pair_bit(s, t) + 1), $sformatf("id for %0d->%0d", s, t));
        bus_op(1'b1, 24'(32'h200004 + t * 32'h1000), 32'(pair_bit(s, t) + 1));
        chk(5, 32'(irq), 32'h0, "irq after complete");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule